// File: doc/BRIEF.md
# PLL Configuration Register Controller

This block holds the two software-visible settings of a clock multiplier: a multiplier code and a post-divider code. It decides, on each register write, whether the new setting may take effect. A write can be refused because the current post-divider is in use, because the multiplier is in limp mode, because the multiplier has been switched off, because the value is reserved, or because the frequency lock has not been re-acquired yet. The analog multiplier is not part of the block. Its lock time is modelled by a cycle counter that runs after each accepted multiplier change.

The block also tracks a limp flag that is raised by a missing-clock event. Software clears it through a write-one-to-clear bit. The block publishes the resulting system clock ratio as a numerator and a denominator for use by the rest of the clock tree. Only the power-on reset and the watchdog reset return the settings to their defaults. A debugger reset clears only the read-data register, and a missing-clock event never resets the settings.

Top module: `pll_cfg_ctrl`

## Requirements
- R1: On power-on reset or watchdog reset, the multiplier becomes 0 (bypass), the post-divider becomes 0, the lock flag becomes 1 and the limp flag becomes 0. The control register (offset 0) then reads 0x0000 and the status register (offset 1) reads 0x0001.
- R2: A debugger reset clears only the read-data output. A debugger reset and a missing-clock event leave the multiplier, the post-divider and the lock state unchanged.
- R3: A write made while `prot_en` is low changes neither register.
- R4: A multiplier write (control register bits 3:0) is ignored in each of these cases: the post-divider is 1 or 2; the limp flag is set; the post-divider is 3 and the written value is nonzero.
- R5: A multiplier write is also ignored in two further cases: the value is 11 to 15; the PLL-off bit (status bit 2) is set and the value is nonzero.
- R6: After an accepted multiplier write, the lock flag reads 0 after that clock edge. It returns to 1 exactly `LOCK_CYCLES` edges after the write edge. A further accepted write restarts the count.
- R7: A write to the post-divider field (status bits 8:7) takes effect if the new value is 0. Otherwise it takes effect only while the lock flag is 1. The value 3 also requires the multiplier to be 0. The bits for PLL off (bit 2), oscillator off (bit 5) and missing-clock detection off (bit 6) take any protected write.
- R8: A missing-clock event sets the limp flag unless detection is off (status bit 6). Writing 1 to status bit 4 clears the limp flag. An event in the same cycle as the clear wins. Bit 4 always reads 0.
- R9: One edge after the settings change, the ratio outputs show the effective ratio. Let M be the multiplier, counted as 1 when it is 0. Post-divider 0 or 1 gives M/4. Post-divider 2 gives M/2. Post-divider 3 gives 1/1.
- R10: `rdata` is registered and shows the register at `addr` as it stood before the edge. Status bit 0 is lock, bit 3 is limp, and bits 2, 5, 6 and 8:7 are as above. Reserved bits and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Synchronous power-on reset, active high |
| wdog_rst | input | 1 | Synchronous watchdog reset, active high |
| dbg_rst | input | 1 | Debugger reset, clears read data only |
| prot_en | input | 1 | Write protection open when high |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register offset |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| mclk_fail | input | 1 | Missing-clock event |
| pll_locked | output | 1 | Lock flag |
| limp | output | 1 | Limp flag |
| mult | output | MULT_W | Current multiplier code |
| divsel | output | 2 | Current post-divider code |
| ratio_num | output | MULT_W | Clock ratio numerator |
| ratio_den | output | 3 | Clock ratio denominator |

## Verification
The first group of results appears one edge after a stimulus: register writes change `mult`, `divsel` and `limp`, and reads appear on `rdata`. The ratio outputs appear one edge later, because they are registered from the settings. The lock flag rises `LOCK_CYCLES` edges after an accepted multiplier write. The bench keeps a reference state that it advances at each rising edge from the inputs it has applied. It compares every output at the following falling edge, so each result is checked in exactly the cycle in which it is due.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;
  localparam int CTRL_OFS   = 0;
  localparam int STAT_OFS   = 1;
  localparam int ST_LOCK    = 0;
  localparam int ST_OFF     = 2;
  localparam int ST_LIMP    = 3;
  localparam int ST_LCLR    = 4;
  localparam int ST_OSCOFF  = 5;
  localparam int ST_MCDOFF  = 6;
  localparam int ST_DIV_LO  = 7;

  typedef enum logic [1:0] {
    DIV_QUARTER0 = 2'd0,
    DIV_QUARTER1 = 2'd1,
    DIV_HALF     = 2'd2,
    DIV_UNITY    = 2'd3
  } postdiv_e;

  typedef struct packed {
    logic pll_off;
    logic osc_off;
    logic mcd_off;
  } stat_ctl_t;
endpackage

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
  parameter int LOCK_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic locked
);
  localparam int CNT_W = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LOCK_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b1;
      cnt_q  <= '0;
    end else if (start) begin
      locked <= 1'b0;
      cnt_q  <= CNT_LOAD;
    end else if (!locked) begin
      if (cnt_q == '0) begin
        locked <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/pll_limp_tracker.sv
module pll_limp_tracker (
  input  logic clk,
  input  logic rst,
  input  logic clk_missing,
  input  logic detect_off,
  input  logic clear_req,
  output logic limp
);
  logic raise;

  assign raise = clk_missing && !detect_off;

  always_ff @(posedge clk) begin
    if (rst) begin
      limp <= 1'b0;
    end else if (raise) begin
      limp <= 1'b1;
    end else if (clear_req) begin
      limp <= 1'b0;
    end
  end
endmodule

// File: rtl/pll_ratio_calc.sv
module pll_ratio_calc import pll_cfg_pkg::*; #(
  parameter int MULT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MULT_W-1:0] mult,
  input  postdiv_e          divsel,
  output logic [MULT_W-1:0] num,
  output logic [2:0]        den
);
  logic [MULT_W-1:0] m_eff;

  assign m_eff = (mult == '0) ? MULT_W'(1) : mult;

  always_ff @(posedge clk) begin
    if (rst) begin
      num <= MULT_W'(1);
      den <= 3'd4;
    end else begin
      unique case (divsel)
        DIV_UNITY: begin
          num <= MULT_W'(1);
          den <= 3'd1;
        end
        DIV_HALF: begin
          num <= m_eff;
          den <= 3'd2;
        end
        default: begin
          num <= m_eff;
          den <= 3'd4;
        end
      endcase
    end
  end
endmodule

// File: rtl/pll_cfg_ctrl.sv
module pll_cfg_ctrl import pll_cfg_pkg::*; #(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 4,
  parameter int MULT_W      = 4,
  parameter int MULT_MAX    = 10,
  parameter int LOCK_CYCLES = 16
) (
  input  logic              clk,
  input  logic              por_rst,
  input  logic              wdog_rst,
  input  logic              dbg_rst,
  input  logic              prot_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              mclk_fail,
  output logic              pll_locked,
  output logic              limp,
  output logic [MULT_W-1:0] mult,
  output logic [1:0]        divsel,
  output logic [MULT_W-1:0] ratio_num,
  output logic [2:0]        ratio_den
);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(STAT_OFS);
  localparam logic [MULT_W-1:0] M_LIMIT  = MULT_W'(MULT_MAX);

  logic              cfg_rst;
  logic              sel_ctrl;
  logic              sel_stat;
  logic [MULT_W-1:0] wr_m;
  postdiv_e          wr_div;
  logic              m_ok_range;
  logic              m_div_busy;
  logic              m_accept;
  logic              div_accept;
  logic              limp_clear;
  logic [MULT_W-1:0] mult_q;
  postdiv_e          div_q;
  stat_ctl_t         ctl_q;
  logic              locked_w;
  logic              limp_w;
  logic [DATA_W-1:0] ctrl_view;
  logic [DATA_W-1:0] stat_view;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_wdata;

  assign cfg_rst  = por_rst | wdog_rst;
  assign sel_ctrl = wr_en && prot_en && (addr == A_CTRL);
  assign sel_stat = wr_en && prot_en && (addr == A_STAT);

  // multiplier write gating
  assign wr_m       = wdata[MULT_W-1:0];
  assign m_ok_range = (wr_m <= M_LIMIT);
  assign m_div_busy = (div_q == DIV_QUARTER1) || (div_q == DIV_HALF);
  assign m_accept   = sel_ctrl && m_ok_range && !m_div_busy && !limp_w
                   && !(ctl_q.pll_off && (wr_m != '0))
                   && !((div_q == DIV_UNITY) && (wr_m != '0));

  // post-divider write gating
  assign wr_div     = postdiv_e'(wdata[ST_DIV_LO+1:ST_DIV_LO]);
  assign div_accept = sel_stat &&
                      ((wr_div == DIV_QUARTER0) ||
                       (locked_w && ((wr_div != DIV_UNITY) || (mult_q == '0))));
  assign limp_clear = sel_stat && wdata[ST_LCLR];

  always_ff @(posedge clk) begin
    if (cfg_rst) begin
      mult_q <= '0;
    end else if (m_accept) begin
      mult_q <= wr_m;
    end
  end

  always_ff @(posedge clk) begin
    if (cfg_rst) begin
      div_q <= DIV_QUARTER0;
      ctl_q <= '0;
    end else if (sel_stat) begin
      ctl_q.pll_off <= wdata[ST_OFF];
      ctl_q.osc_off <= wdata[ST_OSCOFF];
      ctl_q.mcd_off <= wdata[ST_MCDOFF];
      if (div_accept) begin
        div_q <= wr_div;
      end
    end
  end

  pll_lock_timer #(
    .LOCK_CYCLES(LOCK_CYCLES)
  ) u_lock (
    .clk   (clk),
    .rst   (cfg_rst),
    .start (m_accept),
    .locked(locked_w)
  );

  pll_limp_tracker u_limp (
    .clk        (clk),
    .rst        (cfg_rst),
    .clk_missing(mclk_fail),
    .detect_off (ctl_q.mcd_off),
    .clear_req  (limp_clear),
    .limp       (limp_w)
  );

  pll_ratio_calc #(
    .MULT_W(MULT_W)
  ) u_ratio (
    .clk   (clk),
    .rst   (cfg_rst),
    .mult  (mult_q),
    .divsel(div_q),
    .num   (ratio_num),
    .den   (ratio_den)
  );

  // read views with reserved bits forced low
  always_comb begin
    ctrl_view = '0;
    ctrl_view[MULT_W-1:0] = mult_q;
    stat_view = '0;
    stat_view[ST_LOCK]              = locked_w;
    stat_view[ST_OFF]               = ctl_q.pll_off;
    stat_view[ST_LIMP]              = limp_w;
    stat_view[ST_OSCOFF]            = ctl_q.osc_off;
    stat_view[ST_MCDOFF]            = ctl_q.mcd_off;
    stat_view[ST_DIV_LO+1:ST_DIV_LO] = div_q;
    unique case (addr)
      A_CTRL:  rd_mux = ctrl_view;
      A_STAT:  rd_mux = stat_view;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (cfg_rst || dbg_rst) begin
      rdata <= '0;
    end else begin
      rdata <= rd_mux;
    end
  end

  assign unused_wdata = ^{wdata};

  assign pll_locked = locked_w;
  assign limp       = limp_w;
  assign mult       = mult_q;
  assign divsel     = div_q;
endmodule

// File: rtl/pll_cfg_ctrl_chk.sv
module pll_cfg_ctrl_chk #(
  parameter int ADDR_W = 4,
  parameter int MULT_W = 4
) (
  input logic              clk,
  input logic              por_rst,
  input logic              wdog_rst,
  input logic              prot_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              mclk_fail,
  input logic              pll_locked,
  input logic              limp,
  input logic [MULT_W-1:0] mult,
  input logic [1:0]        divsel,
  input logic [MULT_W-1:0] ratio_num,
  input logic [2:0]        ratio_den
);
  // R3
  prot_closed_chk: assert property (@(posedge clk) disable iff (por_rst || wdog_rst)
    (wr_en && !prot_en) |=> ($stable(mult) && $stable(divsel)));

  // R4
  mult_div_busy_chk: assert property (@(posedge clk) disable iff (por_rst || wdog_rst)
    (wr_en && prot_en && (addr == ADDR_W'(0)) && ((divsel == 2'd1) || (divsel == 2'd2)))
    |=> $stable(mult));

  // R6
  lock_drop_cause_chk: assert property (@(posedge clk) disable iff (por_rst || wdog_rst)
    $fell(pll_locked) |-> $past(wr_en && prot_en && (addr == ADDR_W'(0))));

  // R7
  div_needs_lock_chk: assert property (@(posedge clk) disable iff (por_rst || wdog_rst)
    ((divsel != $past(divsel)) && (divsel != 2'd0)) |-> $past(pll_locked));

  // R7
  unity_bypass_chk: assert property (@(posedge clk) disable iff (por_rst || wdog_rst)
    (divsel == 2'd3) |-> (mult == '0));

  // R8
  limp_cause_chk: assert property (@(posedge clk) disable iff (por_rst || wdog_rst)
    $rose(limp) |-> $past(mclk_fail));

  // R9
  unity_ratio_chk: assert property (@(posedge clk) disable iff (por_rst || wdog_rst)
    (ratio_den == 3'd1) |-> (ratio_num == MULT_W'(1)));
endmodule

bind pll_cfg_ctrl pll_cfg_ctrl_chk #(
  .ADDR_W(ADDR_W),
  .MULT_W(MULT_W)
) u_chk (
  .clk       (clk),
  .por_rst   (por_rst),
  .wdog_rst  (wdog_rst),
  .prot_en   (prot_en),
  .wr_en     (wr_en),
  .addr      (addr),
  .mclk_fail (mclk_fail),
  .pll_locked(pll_locked),
  .limp      (limp),
  .mult      (mult),
  .divsel    (divsel),
  .ratio_num (ratio_num),
  .ratio_den (ratio_den)
);

// File: tb/sim_pll_cfg_ctrl.sv
module sim_pll_cfg_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LOCK_CYC   = 16;

  logic        clk = 1'b0;
  logic        por_rst, wdog_rst, dbg_rst, prot_en, wr_en, mclk_fail;
  logic [3:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        pll_locked, limp;
  logic [3:0]  mult, ratio_num;
  logic [1:0]  divsel;
  logic [2:0]  ratio_den;

  int n_chk = 0;
  int n_bad = 0;

  // reference state
  logic [3:0]  m_mult;
  logic [1:0]  m_div;
  logic        m_lock, m_off, m_osc, m_mcd, m_limp;
  int          m_cnt;
  logic [15:0] m_rdata;
  logic [3:0]  m_num;
  logic [2:0]  m_den;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_cfg_ctrl #(.LOCK_CYCLES(LOCK_CYC)) u0 (
    .clk(clk), .por_rst(por_rst), .wdog_rst(wdog_rst), .dbg_rst(dbg_rst),
    .prot_en(prot_en), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .mclk_fail(mclk_fail), .pll_locked(pll_locked), .limp(limp), .mult(mult),
    .divsel(divsel), .ratio_num(ratio_num), .ratio_den(ratio_den)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] ref_read(input logic [3:0] a);
    if (a == 4'd0) return {12'b0, m_mult};
    if (a == 4'd1) return {7'b0, m_div, m_mcd, m_osc, 1'b0, m_limp, m_off, 1'b0, m_lock};
    return 16'h0;
  endfunction

  task automatic ref_reset();
    m_mult = 0; m_div = 0; m_lock = 1; m_off = 0; m_osc = 0; m_mcd = 0;
    m_limp = 0; m_cnt = 0; m_rdata = 0; m_num = 1; m_den = 4;
  endtask

  task automatic tick();
    logic [3:0] d;
    logic [1:0] nd;
    logic       macc;
    if (por_rst || wdog_rst) begin
      @(posedge clk);
      ref_reset();
    end else begin
      // values computed from the state before the edge
      m_rdata = dbg_rst ? 16'h0 : ref_read(addr);
      if (m_div == 2'd3) begin m_num = 1; m_den = 1; end
      else begin
        m_num = (m_mult == 0) ? 4'd1 : m_mult;
        m_den = (m_div == 2'd2) ? 3'd2 : 3'd4;
      end
      d  = wdata[3:0];
      nd = wdata[8:7];
      macc = wr_en && prot_en && addr == 4'd0 && d <= 4'd10 &&
             !(m_div == 2'd1 || m_div == 2'd2) && !m_limp &&
             !(m_off && d != 0) && !(m_div == 2'd3 && d != 0);
      @(posedge clk);
      if (mclk_fail && !m_mcd) m_limp = 1;
      else if (wr_en && prot_en && addr == 4'd1 && wdata[4]) m_limp = 0;
      if (wr_en && prot_en && addr == 4'd1) begin
        if (nd == 0 || (m_lock && (nd != 3 || m_mult == 0))) m_div = nd;
        m_off = wdata[2]; m_osc = wdata[5]; m_mcd = wdata[6];
      end
      if (macc) begin
        m_mult = d; m_lock = 0; m_cnt = LOCK_CYC - 1;
      end else if (!m_lock) begin
        if (m_cnt == 0) m_lock = 1; else m_cnt--;
      end
    end
    @(negedge clk);
    check("R6 lock", pll_locked, m_lock);
    check("R8 limp", limp, m_limp);
    check("R4 mult", mult, m_mult);
    check("R7 divsel", divsel, m_div);
    check("R9 num", ratio_num, m_num);
    check("R9 den", ratio_den, m_den);
    check("R10 rdata", rdata, m_rdata);
  endtask

  task automatic idle_in();
    por_rst = 0; wdog_rst = 0; dbg_rst = 0; wr_en = 0; mclk_fail = 0;
    prot_en = 1; wdata = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wr_en = 1; addr = a; wdata = d; tick(); wr_en = 0; wdata = 0;
  endtask

  task automatic rd(input logic [3:0] a);
    addr = a; tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed_init;
    seed_init = $urandom(32'h7253);
    ref_reset();
    idle_in(); addr = 0;
    por_rst = 1;
    tick(); tick();
    por_rst = 0;
    // R1 reset view
    rd(4'd1);
    check("R1 status after reset", rdata, 16'h0001);
    rd(4'd0);
    check("R1 ctrl after reset", rdata, 16'h0000);
    tick();
    check("R9 bypass ratio num", ratio_num, 1);
    check("R9 bypass ratio den", ratio_den, 4);

    // R3 protection closed
    prot_en = 0; wr(4'd0, 16'h0005); prot_en = 1;
    check("R3 mult unchanged", mult, 0);

    // R6 lock timing
    wr(4'd0, 16'h0005);
    check("R6 lock low after write", pll_locked, 0);
    repeat (LOCK_CYC - 1) tick();
    check("R6 lock still low", pll_locked, 0);
    tick();
    check("R6 lock back high", pll_locked, 1);

    // R5 reserved value
    wr(4'd0, 16'h000C);
    check("R5 reserved ignored", mult, 5);

    // R7 divsel 2 while locked, then R4 write blocked
    wr(4'd1, 16'h0100);
    check("R7 divsel half", divsel, 2);
    tick();
    check("R9 half ratio den", ratio_den, 2);
    check("R9 half ratio num", ratio_num, 5);
    wr(4'd0, 16'h0007);
    check("R4 blocked by divsel", mult, 5);
    wr(4'd1, 16'h0180);
    check("R7 unity needs bypass", divsel, 2);
    wr(4'd1, 16'h0000);
    check("R7 back to zero", divsel, 0);
    wr(4'd0, 16'h0000);
    wr(4'd1, 16'h0180);
    check("R7 unity while unlocked", divsel, 0);
    repeat (LOCK_CYC) tick();
    wr(4'd1, 16'h0180);
    check("R7 unity in bypass", divsel, 3);
    wr(4'd0, 16'h0003);
    check("R4 nonzero blocked in unity", mult, 0);
    wr(4'd1, 16'h0000);

    // R5 pll off
    wr(4'd1, 16'h0004);
    wr(4'd0, 16'h0004);
    check("R5 pll off blocks", mult, 0);
    wr(4'd1, 16'h0000);

    // R8 limp
    mclk_fail = 1; tick(); mclk_fail = 0;
    check("R8 limp set", limp, 1);
    wr(4'd0, 16'h0002);
    check("R4 blocked by limp", mult, 0);
    rd(4'd1); rd(4'd1);
    check("R8 clear bit reads 0", rdata[4], 0);
    mclk_fail = 1; wr(4'd1, 16'h0010); mclk_fail = 0;
    check("R8 event beats clear", limp, 1);
    wr(4'd1, 16'h0010);
    check("R8 cleared", limp, 0);
    wr(4'd1, 16'h0040);
    mclk_fail = 1; tick(); mclk_fail = 0;
    check("R8 detect off", limp, 0);
    wr(4'd1, 16'h0000);

    // R2 debugger reset keeps settings
    wr(4'd0, 16'h0009);
    repeat (LOCK_CYC) tick();
    dbg_rst = 1; addr = 0; tick(); dbg_rst = 0;
    check("R2 dbg keeps mult", mult, 9);
    check("R2 dbg clears rdata", rdata, 0);
    wdog_rst = 1; tick(); wdog_rst = 0;
    check("R1 watchdog reset mult", mult, 0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      wr_en     = (r[3:0] < 5);
      prot_en   = (r[7:4] != 0);
      addr      = {2'b0, r[9:8] == 3 ? 2'd2 : r[9:8]};
      mclk_fail = (r[15:10] == 0);
      dbg_rst   = (r[21:16] == 1);
      wdog_rst  = (r[29:22] == 2);
      wdata     = r[30] ? 16'($urandom) : (16'($urandom) & 16'h01EF);
      tick();
    end
    idle_in();
    tick();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule